// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block compares every memory access and instruction fetch against four breakpoint address registers. Each breakpoint has its own access-type and length codes, both held in one control word, and its own local and global enables. The compare runs combinationally in the cycle of the access. A match that is enabled makes a one-cycle trap request on the next clock edge.

Each matching breakpoint sets a sticky bit in a status word, whether or not that breakpoint is enabled. A single-step pulse also sets a status bit of its own and raises a trap. A task-switch pulse clears the local enables and the local exact bit, and leaves the global enables and the global exact bit as they were. Software reaches all registers through a select/read/write port. Only privilege level 0 may use this port. Any other level changes no state and raises a protection-fault flag instead.

Register selects: 0 to 3 are the breakpoint addresses, 6 is status and 7 is control. Control word layout:
- bits [3:0] hold the local enables for breakpoints 0 to 3;
- bits [7:4] hold the global enables for breakpoints 0 to 3;
- bit 8 is the local exact bit and bit 9 is the global exact bit;
- the type code of breakpoint n sits at bits [17+2n:16+2n];
- the length code of breakpoint n sits at bits [25+2n:24+2n].

Status word layout: bits [3:0] are the per-breakpoint match flags and bit 4 is the single-step flag.

The trap sequencer is a two-state machine:
- TRAP_IDLE moves to TRAP_FIRE on a qualifying event (TRIG).
- TRAP_FIRE moves back to TRAP_IDLE when there is no new event (DONE).
- TRAP_FIRE stays in TRAP_FIRE on a further event (RETRIG).

Top module: `bkpt_watch`

## Requirements
- R1: Access kind codes are 0 fetch, 1 read and 2 write. Type code 00 breaks on fetch only. Type 01 breaks on writes only. Type 11 breaks on reads or writes but never on fetches. Type 10 never matches.
- R2: Length code 00 covers one byte, 01 covers two bytes and 11 covers four bytes, and code 10 never matches. The length clears the low address bits of the breakpoint, so a two-byte range starts at a multiple of 2 and a four-byte range at a multiple of 4.
- R3: An execution breakpoint matches only a fetch whose address equals the breakpoint address exactly, and only with length code 00. With any other length it never matches.
- R4: A data breakpoint matches when any byte of the access (address up to address+size-1, size 1, 2 or 4) lies inside its range.
- R5: trap_req is high for the cycle after an access cycle in which a matching breakpoint has its local or its global enable set. A match with both enables clear gives no trap.
- R6: A match sets status bit n even when breakpoint n is disabled. Status bits are never cleared by hardware and change to 0 only through a software write.
- R7: A single_step pulse sets status bit 4 and raises trap_req in the next cycle.
- R8: task_switch clears control bits [3:0] and bit 8, and keeps bits [7:4] and bit 9.
- R9: A register access with cpl not 0 leaves every register unchanged, reads as 0, and sets prot_fault for the next cycle.
- R10: At cpl 0, a write to select 0-3, 6 or 7 updates that register, and reg_rdata returns it in the same cycle. Other selects read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Linear address of the access |
| acc_size | input | 3 | Byte count of the access: 1, 2 or 4 |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write |
| task_switch | input | 1 | Task-switch pulse |
| single_step | input | 1 | Single-step pulse |
| cpl | input | 2 | Current privilege level |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 write, 0 read |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| trap_req | output | 1 | One-cycle debug trap request |
| prot_fault | output | 1 | Privilege violation flag, one cycle |
| status_out | output | 32 | Status register contents |

## Verification
trap_req, prot_fault and status_out are due in the cycle after the stimulus cycle, because each passes through one register. reg_rdata is combinational and is due in the stimulus cycle itself. The driver stamps each expectation with the cycle index in which it is due. The monitor compares it at the falling edge of that cycle, after inputs have been applied shortly after the rising edge. Each stimulus task also pushes a trap_req expectation for the cycle that follows, which checks the single-cycle width of every pulse.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int NUM_BP     = 4;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int SEL_W      = 3;
    localparam int LOC_LSB    = 0;
    localparam int GLB_LSB    = NUM_BP;
    localparam int LEXACT_BIT = 2 * NUM_BP;
    localparam int GEXACT_BIT = 2 * NUM_BP + 1;
    localparam int TYPE_LSB   = 16;
    localparam int LEN_LSB    = TYPE_LSB + 2 * NUM_BP;
    localparam int STEP_BIT   = NUM_BP;
    localparam logic [SEL_W-1:0] SEL_STATUS = 3'd6;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd7;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_NONE  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        BT_EXEC  = 2'b00,
        BT_WRITE = 2'b01,
        BT_BAD   = 2'b10,
        BT_RDWR  = 2'b11
    } bp_type_e;

    typedef enum logic [1:0] {
        BL_ONE  = 2'b00,
        BL_TWO  = 2'b01,
        BL_BAD  = 2'b10,
        BL_FOUR = 2'b11
    } bp_len_e;

    typedef enum logic {
        TRAP_IDLE = 1'b0,
        TRAP_FIRE = 1'b1
    } trap_state_e;
endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
    import bkpt_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic [2:0]    acc_size,
    input  acc_kind_e     kind,
    input  logic [AW-1:0] bp_addr,
    input  bp_type_e      bp_type,
    input  bp_len_e       bp_len,
    output logic          hit
);
    logic [AW:0] mask;
    logic [AW:0] rng_lo;
    logic [AW:0] rng_hi;
    logic [AW:0] a_lo;
    logic [AW:0] a_hi;
    logic        len_ok;
    logic        overlap;
    logic        match;

    always_comb begin
        len_ok = 1'b1;
        case (bp_len)
            BL_ONE:  mask = '0;
            BL_TWO:  mask = (AW+1)'(1);
            BL_FOUR: mask = (AW+1)'(3);
            default: begin
                mask   = '0;
                len_ok = 1'b0;
            end
        endcase
        rng_lo  = {1'b0, bp_addr} & ~mask;
        rng_hi  = rng_lo | mask;
        a_lo    = {1'b0, acc_addr};
        a_hi    = a_lo + {{(AW-2){1'b0}}, acc_size} - (AW+1)'(1);
        overlap = len_ok && (acc_size != 3'd0) && (a_lo <= rng_hi) && (a_hi >= rng_lo);
        case (bp_type)
            BT_EXEC:  match = (kind == KIND_FETCH) && (bp_len == BL_ONE) && (acc_addr == bp_addr);
            BT_WRITE: match = (kind == KIND_WRITE) && overlap;
            BT_RDWR:  match = ((kind == KIND_READ) || (kind == KIND_WRITE)) && overlap;
            default:  match = 1'b0;
        endcase
        hit = acc_valid && match;
    end
endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int NB = NUM_BP,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int SW = SEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_en,
    input  logic                   reg_we,
    input  logic [SW-1:0]          reg_sel,
    input  logic [DW-1:0]          reg_wdata,
    input  logic [1:0]             cpl,
    input  logic [NB-1:0]          hits,
    input  logic                   task_switch,
    input  logic                   single_step,
    output logic [NB-1:0][AW-1:0]  bp_addr,
    output logic [DW-1:0]          ctrl_q,
    output logic [DW-1:0]          status_q,
    output logic [DW-1:0]          reg_rdata,
    output logic                   prot_fault
);
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    logic allowed;
    logic wr;

    assign allowed = reg_en && (cpl == 2'd0);
    assign wr      = allowed && reg_we;

    for (genvar g = 0; g < NB; g++) begin : g_addr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bp_addr[g] <= '0;
            end else if (wr && (reg_sel == SW'(g))) begin
                bp_addr[g] <= reg_wdata[AW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            logic [DW-1:0] c;
            c = ctrl_q;
            if (wr && (reg_sel == SEL_CTRL)) c = reg_wdata;
            if (task_switch) begin
                c[LOC_LSB +: NB] = '0;
                c[LEXACT_BIT]    = 1'b0;
            end
            ctrl_q <= c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            logic [DW-1:0] s;
            s = status_q;
            if (wr && (reg_sel == SEL_STATUS)) s = reg_wdata;
            s[NB-1:0] = s[NB-1:0] | hits;
            if (single_step) s[STEP_BIT] = 1'b1;
            status_q <= s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prot_fault <= 1'b0;
        else        prot_fault <= reg_en && (cpl != 2'd0);
    end

    always_comb begin
        reg_rdata = '0;
        if (allowed) begin
            if (reg_sel < SW'(NB))           reg_rdata = DW'(bp_addr[reg_sel[IW-1:0]]);
            else if (reg_sel == SEL_STATUS)  reg_rdata = status_q;
            else if (reg_sel == SEL_CTRL)    reg_rdata = ctrl_q;
        end
    end
endmodule

// File: rtl/bkpt_trap_fsm.sv
module bkpt_trap_fsm
    import bkpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic trap_req
);
    trap_state_e state;
    trap_state_e state_nx;

    always_comb begin
        unique case (state)
            TRAP_IDLE: state_nx = fire ? TRAP_FIRE : TRAP_IDLE;
            TRAP_FIRE: state_nx = fire ? TRAP_FIRE : TRAP_IDLE;
            default:   state_nx = TRAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TRAP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        trap_req = (state == TRAP_FIRE);
    end
endmodule

// File: rtl/bkpt_watch.sv
module bkpt_watch
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_size,
    input  logic [1:0]        acc_kind,
    input  logic              task_switch,
    input  logic              single_step,
    input  logic [1:0]        cpl,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              trap_req,
    output logic              prot_fault,
    output logic [DATA_W-1:0] status_out
);
    logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr;
    logic [DATA_W-1:0]             ctrl_word;
    logic [NUM_BP-1:0]             hits;
    logic [NUM_BP-1:0]             enabled;
    logic                          fire;

    bkpt_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_en      (reg_en),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .cpl         (cpl),
        .hits        (hits),
        .task_switch (task_switch),
        .single_step (single_step),
        .bp_addr     (bp_addr),
        .ctrl_q      (ctrl_word),
        .status_q    (status_out),
        .reg_rdata   (reg_rdata),
        .prot_fault  (prot_fault)
    );

    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
        bkpt_cmp #(.AW(ADDR_W)) u_cmp (
            .acc_valid (acc_valid),
            .acc_addr  (acc_addr),
            .acc_size  (acc_size),
            .kind      (acc_kind_e'(acc_kind)),
            .bp_addr   (bp_addr[g]),
            .bp_type   (bp_type_e'(ctrl_word[TYPE_LSB + 2*g +: 2])),
            .bp_len    (bp_len_e'(ctrl_word[LEN_LSB + 2*g +: 2])),
            .hit       (hits[g])
        );
    end

    assign enabled = ctrl_word[LOC_LSB +: NUM_BP] | ctrl_word[GLB_LSB +: NUM_BP];
    assign fire    = (|(hits & enabled)) || single_step;

    bkpt_trap_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .trap_req (trap_req)
    );
endmodule

// File: rtl/bkpt_watch_chk.sv
module bkpt_watch_chk
    import bkpt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              single_step,
    input logic              task_switch,
    input logic              reg_en,
    input logic              reg_we,
    input logic [SEL_W-1:0]  reg_sel,
    input logic [1:0]        cpl,
    input logic              trap_req,
    input logic              prot_fault,
    input logic [DATA_W-1:0] status_out,
    input logic [DATA_W-1:0] ctrl_word
);
    logic sw_status_wr;
    logic sw_ctrl_wr;
    logic bad_access;

    assign sw_status_wr = reg_en && reg_we && (reg_sel == SEL_STATUS) && (cpl == 2'd0);
    assign sw_ctrl_wr   = reg_en && reg_we && (reg_sel == SEL_CTRL) && (cpl == 2'd0);
    assign bad_access   = reg_en && (cpl != 2'd0);

    assert_trap_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(acc_valid || single_step));

    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_status_wr |=> ((status_out & $past(status_out)) == $past(status_out)));

    assert_step_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        single_step |=> (status_out[STEP_BIT] && trap_req));

    assert_local_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (task_switch && !sw_ctrl_wr) |=>
            ((ctrl_word[LOC_LSB +: NUM_BP] == '0) && !ctrl_word[LEXACT_BIT] &&
             (ctrl_word[GLB_LSB +: NUM_BP] == $past(ctrl_word[GLB_LSB +: NUM_BP])) &&
             (ctrl_word[GEXACT_BIT] == $past(ctrl_word[GEXACT_BIT]))));

    assert_fault_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |=> prot_fault);

    assert_fault_safe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_access && !acc_valid && !single_step && !task_switch) |=>
            ($stable(status_out) && $stable(ctrl_word)));
endmodule

bind bkpt_watch bkpt_watch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .single_step (single_step),
    .task_switch (task_switch),
    .reg_en      (reg_en),
    .reg_we      (reg_we),
    .reg_sel     (reg_sel),
    .cpl         (cpl),
    .trap_req    (trap_req),
    .prot_fault  (prot_fault),
    .status_out  (status_out),
    .ctrl_word   (ctrl_word)
);

// File: tb/bkpt_watch_tb.sv
`timescale 1ns/1ps
module bkpt_watch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [2:0]  acc_size = 3'd1;
    logic [1:0]  acc_kind = 2'd3;
    logic        task_switch = 1'b0;
    logic        single_step = 1'b0;
    logic [1:0]  cpl = 2'd0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        trap_req;
    logic        prot_fault;
    logic [31:0] status_out;

    always #4 clk = ~clk;

    bkpt_watch u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_kind(acc_kind), .task_switch(task_switch),
        .single_step(single_step), .cpl(cpl), .reg_en(reg_en), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trap_req(trap_req), .prot_fault(prot_fault), .status_out(status_out)
    );

    typedef struct {
        int          due;
        int          what;
        logic [31:0] exp;
        string       tag;
    } item_t;

    localparam int W_TRAP = 0, W_STATUS = 1, W_FAULT = 2, W_RDATA = 3;

    item_t       sbq[$];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;
    logic [31:0] m_addr [4];
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_status = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void push(int due, int what, logic [31:0] e, string tag);
        item_t it;
        it.due = due; it.what = what; it.exp = e; it.tag = tag;
        sbq.push_back(it);
    endfunction

    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t       it;
            logic [31:0] act;
            it = sbq.pop_front();
            case (it.what)
                W_TRAP:   act = {31'd0, trap_req};
                W_STATUS: act = status_out;
                W_FAULT:  act = {31'd0, prot_fault};
                default:  act = reg_rdata;
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    function automatic logic model_hit(logic [31:0] a, int sz, logic [1:0] k, int n);
        logic [1:0]  t;
        logic [1:0]  l;
        int          span;
        logic [32:0] lo;
        logic        ov;
        t = m_ctrl[16 + 2*n +: 2];
        l = m_ctrl[24 + 2*n +: 2];
        if (t == 2'b00) return (k == 2'd0) && (l == 2'b00) && (a == m_addr[n]);
        if (t == 2'b10 || l == 2'b10) return 1'b0;
        span = (l == 2'b00) ? 1 : (l == 2'b01) ? 2 : 4;
        lo = {1'b0, m_addr[n]} & ~(33'(span - 1));
        ov = 1'b0;
        for (int i = 0; i < sz; i++) begin
            logic [32:0] b;
            b = {1'b0, a} + 33'(i);
            if (b >= lo && b < lo + 33'(span)) ov = 1'b1;
        end
        if (t == 2'b01) return (k == 2'd2) && ov;
        return ((k == 2'd1) || (k == 2'd2)) && ov;
    endfunction

    function automatic logic [31:0] cfg(int n, logic [1:0] t, logic [1:0] l);
        return (32'(t) << (16 + 2*n)) | (32'(l) << (24 + 2*n));
    endfunction

    task automatic start_cycle();
        @(posedge clk);
        #2;
        acc_valid = 1'b0; task_switch = 1'b0; single_step = 1'b0;
        reg_en = 1'b0; reg_we = 1'b0; cpl = 2'd0;
    endtask

    task automatic do_access(logic [31:0] a, int sz, logic [1:0] k, string tag);
        logic fire;
        start_cycle();
        acc_valid = 1'b1; acc_addr = a; acc_size = 3'(sz); acc_kind = k;
        fire = 1'b0;
        for (int n = 0; n < 4; n++) begin
            if (model_hit(a, sz, k, n)) begin
                m_status[n] = 1'b1;
                if (m_ctrl[n] || m_ctrl[4+n]) fire = 1'b1;
            end
        end
        push(cyc + 1, W_TRAP, {31'd0, fire}, tag);
        push(cyc + 1, W_STATUS, m_status, tag);
    endtask

    task automatic write_reg(logic [2:0] sel, logic [31:0] d, logic [1:0] lvl, string tag);
        start_cycle();
        reg_en = 1'b1; reg_we = 1'b1; reg_sel = sel; reg_wdata = d; cpl = lvl;
        if (lvl == 2'd0) begin
            if (sel < 3'd4)      m_addr[sel[1:0]] = d;
            else if (sel == 3'd6) m_status = d;
            else if (sel == 3'd7) m_ctrl = d;
        end
        push(cyc + 1, W_FAULT, {31'd0, (lvl != 2'd0)}, tag);
        push(cyc + 1, W_TRAP, 32'd0, tag);
    endtask

    task automatic read_reg(logic [2:0] sel, logic [1:0] lvl, string tag);
        logic [31:0] e;
        start_cycle();
        reg_en = 1'b1; reg_we = 1'b0; reg_sel = sel; cpl = lvl;
        e = '0;
        if (lvl == 2'd0) begin
            if (sel < 3'd4)       e = m_addr[sel[1:0]];
            else if (sel == 3'd6) e = m_status;
            else if (sel == 3'd7) e = m_ctrl;
        end
        push(cyc, W_RDATA, e, tag);
        push(cyc + 1, W_FAULT, {31'd0, (lvl != 2'd0)}, tag);
        push(cyc + 1, W_TRAP, 32'd0, tag);
    endtask

    task automatic do_step();
        start_cycle();
        single_step = 1'b1;
        m_status[4] = 1'b1;
        push(cyc + 1, W_TRAP, 32'd1, "R7 step trap");
        push(cyc + 1, W_STATUS, m_status, "R7 step status");
    endtask

    task automatic do_tswitch();
        start_cycle();
        task_switch = 1'b1;
        m_ctrl[3:0] = 4'd0;
        m_ctrl[8] = 1'b0;
        push(cyc + 1, W_TRAP, 32'd0, "R8 switch no trap");
    endtask

    task automatic idle();
        start_cycle();
        push(cyc + 1, W_TRAP, 32'd0, "R5 idle no trap");
    endtask

    initial begin
        logic [31:0] ctrl_a;
        for (int i = 0; i < 4; i++) m_addr[i] = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        push(cyc, W_TRAP, 32'd0, "R5 reset trap");
        push(cyc, W_STATUS, 32'd0, "R6 reset status");
        push(cyc, W_FAULT, 32'd0, "R9 reset fault");

        // R10 register setup and readback
        write_reg(3'd0, 32'h0000_1000, 2'd0, "R10 wr a0");
        write_reg(3'd1, 32'h0000_2002, 2'd0, "R10 wr a1");
        write_reg(3'd2, 32'h0000_3005, 2'd0, "R10 wr a2");
        write_reg(3'd3, 32'h0000_4000, 2'd0, "R10 wr a3");
        ctrl_a = cfg(0, 2'b00, 2'b00) | cfg(1, 2'b01, 2'b01) | cfg(2, 2'b11, 2'b11) |
                 cfg(3, 2'b10, 2'b00) | 32'h0000_0001 | 32'h0000_0008 | 32'h0000_0020;
        write_reg(3'd7, ctrl_a, 2'd0, "R10 wr ctrl");
        read_reg(3'd2, 2'd0, "R10 rd a2");
        read_reg(3'd7, 2'd0, "R10 rd ctrl");
        read_reg(3'd5, 2'd0, "R10 rd unused sel");

        // R3 execution breakpoint
        do_access(32'h1000, 1, 2'd0, "R3 fetch exact");
        do_access(32'h1001, 1, 2'd0, "R3 fetch off by one");
        do_access(32'h1000, 1, 2'd1, "R1 read on exec bp");
        write_reg(3'd6, 32'd0, 2'd0, "R6 clear status");
        // R1 / R2 / R4 data breakpoints
        do_access(32'h2003, 1, 2'd2, "R4 write hi byte of 2-byte range");
        do_access(32'h2002, 1, 2'd1, "R1 read on write-only bp");
        do_access(32'h2000, 4, 2'd2, "R4 dword write overlap");
        do_access(32'h2004, 2, 2'd2, "R2 write just past range");
        do_access(32'h2002, 1, 2'd0, "R1 fetch on write bp");
        write_reg(3'd6, 32'd0, 2'd0, "R6 clear status");
        do_access(32'h3006, 1, 2'd1, "R6 disabled bp sets status");
        idle();
        do_access(32'h3002, 2, 2'd2, "R2 below aligned range");
        do_access(32'h3003, 2, 2'd2, "R4 straddling access");
        do_access(32'h4000, 1, 2'd2, "R1 undefined type");
        idle();
        read_reg(3'd6, 2'd0, "R6 status sticky");
        write_reg(3'd6, 32'd0, 2'd0, "R6 sw clear");
        idle();

        // R7 single step
        do_step();
        do_access(32'h3004, 4, 2'd2, "R7 step plus data");
        write_reg(3'd6, 32'd0, 2'd0, "R6 sw clear");

        // R8 task switch
        write_reg(3'd7, ctrl_a | 32'h0000_0300, 2'd0, "R10 ctrl exact bits");
        do_tswitch();
        read_reg(3'd7, 2'd0, "R8 ctrl after switch");
        do_access(32'h1000, 1, 2'd0, "R8 local gone");
        do_access(32'h2002, 2, 2'd2, "R8 global kept");

        // R9 privilege
        write_reg(3'd7, 32'hFFFF_FFFF, 2'd3, "R9 wr ctrl cpl3");
        write_reg(3'd0, 32'h0000_5555, 2'd1, "R9 wr a0 cpl1");
        read_reg(3'd7, 2'd0, "R9 ctrl unchanged");
        read_reg(3'd0, 2'd0, "R9 a0 unchanged");
        read_reg(3'd6, 2'd2, "R9 rd status cpl2");
        write_reg(3'd6, 32'd0, 2'd3, "R9 wr status cpl3");
        idle();
        read_reg(3'd6, 2'd0, "R9 status unchanged");

        // R2 / R3 undefined length codes
        write_reg(3'd6, 32'd0, 2'd0, "R6 sw clear");
        write_reg(3'd7, cfg(0, 2'b11, 2'b10) | cfg(1, 2'b00, 2'b01) | 32'h0000_0030,
                  2'd0, "R10 ctrl undefined len");
        do_access(32'h1000, 1, 2'd1, "R2 len code 10");
        do_access(32'h2002, 1, 2'd0, "R3 exec with len 01");
        idle();
        idle();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule